// File: doc/BRIEF.md
# Tile Floored Remainder Engine

This block computes the elementwise floored remainder of two integer tiles held in local buffers. A start pulse carries an element mode and a valid row and column count. The block then visits every element of that valid sub-region of a fixed-capacity row-major tile, one at a time. For each element it reads one operand from each source buffer, derives a truncated remainder with a one-bit-per-cycle restoring divider working on magnitudes, corrects the sign so that the result follows the divisor, and writes the result to the destination buffer.

Signed and unsigned 16-bit and 32-bit elements are supported. A zero divisor writes zero and raises a sticky error flag. A single-cycle done pulse marks the end of an operation.

Top module: `tile_fmod_engine`

## Requirements
- R1: In signed modes each written value equals dividend - floor(dividend/divisor) * divisor. A nonzero result therefore always carries the divisor's sign, never the dividend's.
- R2: In unsigned modes the written value is the plain remainder of the unsigned operands, with no sign correction.
- R3: mode_i selects the element type: 0 = unsigned 16-bit, 1 = signed 16-bit, 2 = unsigned 32-bit, 3 = signed 32-bit. In 16-bit modes only bits [15:0] of each operand are used, and the result sits in bits [15:0] with bits [31:16] zero.
- R4: In signed modes the most negative dividend modulo -1 gives zero.
- R5: Elements are visited in row-major order, row by row and column by column within a row. Element (i, j) uses address i*COLS + j. Both source reads of an element use the same address, and the destination write uses that address too.
- R6: Only elements inside the valid region are read or written, each exactly once. No read occurs in a cycle with a write.
- R7: A zero divisor writes zero and sets dz_err_o, which then stays high until reset.
- R8: Mode, row count and column count are latched on an accepted start. Input changes and start pulses while busy_o is high have no effect.
- R9: A start with zero rows or zero columns gives done_o in the cycle after start. It makes no buffer access and busy_o stays low.
- R10: busy_o rises in the cycle after an accepted start. done_o is a one-cycle pulse in the cycle after the final write, and busy_o falls in that same cycle.
- R11: Source reads have one cycle of latency: read data is taken in the cycle after the read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, accepted only while idle |
| mode_i | input | 2 | Element mode (see R3) |
| rows_i | input | $clog2(ROWS+1) | Valid row count |
| cols_i | input | $clog2(COLS+1) | Valid column count |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | End-of-operation pulse |
| dz_err_o | output | 1 | Sticky zero-divisor flag |
| a_re_o | output | 1 | Dividend buffer read enable |
| a_raddr_o | output | $clog2(ROWS*COLS) | Dividend buffer read address |
| a_rdata_i | input | 32 | Dividend read data, one cycle after enable |
| b_re_o | output | 1 | Divisor buffer read enable |
| b_raddr_o | output | $clog2(ROWS*COLS) | Divisor buffer read address |
| b_rdata_i | input | 32 | Divisor read data, one cycle after enable |
| d_we_o | output | 1 | Destination write enable |
| d_waddr_o | output | $clog2(ROWS*COLS) | Destination write address |
| d_wdata_o | output | 32 | Destination write data |

## Verification
The assertions assume that both source buffers return data exactly one cycle after a read enable. They also assume the counts on an accepted start do not exceed the tile capacity, because the region and data checks compare writes against operands the checker captured at that latency. The bench models each buffer as a synchronous array with that single-cycle latency and only issues counts within ROWS and COLS. It keeps the high operand bits random in 16-bit modes and places zero divisors only in the dedicated zero-divisor run.

// File: rtl/tfmod_pkg.sv
package tfmod_pkg;
  localparam int ELEM_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    M_U16 = 2'd0,
    M_S16 = 2'd1,
    M_U32 = 2'd2,
    M_S32 = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_LD,
    S_DIV,
    S_WR
  } state_e;

  function automatic logic is_signed(mode_e m);
    return m[0];
  endfunction

  function automatic logic is_narrow(mode_e m);
    return ~m[1];
  endfunction

  // bring an operand to full width according to the element mode
  function automatic logic [ELEM_W-1:0] widen(mode_e m, logic [ELEM_W-1:0] x);
    logic [ELEM_W-1:0] r;
    case (m)
      M_U16:   r = {{(ELEM_W-HALF_W){1'b0}}, x[HALF_W-1:0]};
      M_S16:   r = {{(ELEM_W-HALF_W){x[HALF_W-1]}}, x[HALF_W-1:0]};
      default: r = x;
    endcase
    return r;
  endfunction

  function automatic logic [ELEM_W-1:0] mag(logic sgn, logic [ELEM_W-1:0] x);
    return (sgn && x[ELEM_W-1]) ? -x : x;
  endfunction
endpackage

// File: rtl/tfmod_walker.sv
module tfmod_walker #(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [$clog2(ROWS+1)-1:0]     rows_i,
  input  logic [$clog2(COLS+1)-1:0]     cols_i,
  input  logic                          adv_i,
  output logic [$clog2(ROWS*COLS)-1:0]  addr_o,
  output logic                          last_o
);
  localparam int AW = $clog2(ROWS*COLS);
  localparam int RW = $clog2(ROWS+1);
  localparam int CW = $clog2(COLS+1);

  logic [RW-1:0] row_q, nrows_q;
  logic [CW-1:0] col_q, ncols_q;
  logic [AW-1:0] base_q;
  logic          row_end;

  assign row_end = (col_q == ncols_q - CW'(1));
  assign last_o  = row_end && (row_q == nrows_q - RW'(1));
  assign addr_o  = base_q + AW'(col_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      col_q   <= '0;
      base_q  <= '0;
      nrows_q <= '0;
      ncols_q <= '0;
    end else if (load_i) begin
      row_q   <= '0;
      col_q   <= '0;
      base_q  <= '0;
      nrows_q <= rows_i;
      ncols_q <= cols_i;
    end else if (adv_i) begin
      if (row_end) begin
        col_q  <= '0;
        row_q  <= row_q + RW'(1);
        base_q <= base_q + AW'(COLS);  // stride by tile capacity
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/tfmod_div.sv
module tfmod_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] rem_o
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     rem_q, dq_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [W:0]       rem_sh, diff;
  logic             ge;

  assign rem_sh = {rem_q, dq_q[W-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};
  assign ge     = ~diff[W];
  assign done_o = done_q;
  assign rem_o  = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dq_q   <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      dq_q   <= dvd_i;
      dvs_q  <= dvs_i;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      rem_q <= ge ? diff[W-1:0] : rem_sh[W-1:0];
      dq_q  <= {dq_q[W-2:0], ge};
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(W-1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tfmod_fix.sv
module tfmod_fix
  import tfmod_pkg::*;
(
  input  mode_e             mode_i,
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  input  logic [ELEM_W-1:0] rem_mag_i,
  output logic [ELEM_W-1:0] res_o
);
  logic              a_neg, b_neg;
  logic [ELEM_W-1:0] trunc, adj;

  always_comb begin
    a_neg = is_signed(mode_i) & a_i[ELEM_W-1];
    b_neg = is_signed(mode_i) & b_i[ELEM_W-1];
    trunc = a_neg ? -rem_mag_i : rem_mag_i;
    // move a remainder of the wrong sign into the divisor's half-line
    adj   = ((trunc != '0) && (a_neg != b_neg)) ? trunc + b_i : trunc;
    res_o = is_narrow(mode_i) ? {{(ELEM_W-HALF_W){1'b0}}, adj[HALF_W-1:0]} : adj;
  end
endmodule

// File: rtl/tile_fmod_engine.sv
module tile_fmod_engine
  import tfmod_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [1:0]                    mode_i,
  input  logic [$clog2(ROWS+1)-1:0]     rows_i,
  input  logic [$clog2(COLS+1)-1:0]     cols_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          dz_err_o,
  output logic                          a_re_o,
  output logic [$clog2(ROWS*COLS)-1:0]  a_raddr_o,
  input  logic [31:0]                   a_rdata_i,
  output logic                          b_re_o,
  output logic [$clog2(ROWS*COLS)-1:0]  b_raddr_o,
  input  logic [31:0]                   b_rdata_i,
  output logic                          d_we_o,
  output logic [$clog2(ROWS*COLS)-1:0]  d_waddr_o,
  output logic [31:0]                   d_wdata_o
);
  localparam int AW = $clog2(ROWS*COLS);

  state_e            state_q;
  mode_e             mode_q;
  logic [ELEM_W-1:0] a_q, b_q, res_q, a_w, b_w, fix_res, div_rem;
  logic              done_q, dz_q, div_start, div_done, last, load;
  logic [AW-1:0]     addr;

  assign load      = (state_q == S_IDLE) && start_i;
  assign a_w       = widen(mode_q, a_rdata_i);
  assign b_w       = widen(mode_q, b_rdata_i);
  assign div_start = (state_q == S_LD) && (b_w != '0);

  tfmod_walker #(.ROWS(ROWS), .COLS(COLS)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .rows_i (rows_i),
    .cols_i (cols_i),
    .adv_i  (state_q == S_WR),
    .addr_o (addr),
    .last_o (last)
  );

  tfmod_div #(.W(ELEM_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .dvd_i   (mag(is_signed(mode_q), a_w)),
    .dvs_i   (mag(is_signed(mode_q), b_w)),
    .done_o  (div_done),
    .rem_o   (div_rem)
  );

  tfmod_fix u_fix (
    .mode_i    (mode_q),
    .a_i       (a_q),
    .b_i       (b_q),
    .rem_mag_i (div_rem),
    .res_o     (fix_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= M_U16;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          mode_q <= mode_e'(mode_i);
          if (rows_i == '0 || cols_i == '0) done_q <= 1'b1;
          else state_q <= S_RD;
        end
        S_RD: state_q <= S_LD;
        S_LD: begin
          a_q <= a_w;
          b_q <= b_w;
          if (b_w == '0) begin
            res_q   <= '0;
            dz_q    <= 1'b1;
            state_q <= S_WR;
          end else begin
            state_q <= S_DIV;
          end
        end
        S_DIV: if (div_done) begin
          res_q   <= fix_res;
          state_q <= S_WR;
        end
        S_WR: begin
          if (last) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= S_RD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign dz_err_o  = dz_q;
  assign a_re_o    = (state_q == S_RD);
  assign b_re_o    = (state_q == S_RD);
  assign a_raddr_o = addr;
  assign b_raddr_o = addr;
  assign d_we_o    = (state_q == S_WR);
  assign d_waddr_o = addr;
  assign d_wdata_o = res_q;
endmodule

// File: rtl/tfmod_chk.sv
module tfmod_chk
  import tfmod_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          start_i,
  input logic [1:0]                    mode_i,
  input logic [$clog2(ROWS+1)-1:0]     rows_i,
  input logic [$clog2(COLS+1)-1:0]     cols_i,
  input logic                          busy_o,
  input logic                          done_o,
  input logic                          dz_err_o,
  input logic                          a_re_o,
  input logic [$clog2(ROWS*COLS)-1:0]  a_raddr_o,
  input logic [31:0]                   a_rdata_i,
  input logic                          b_re_o,
  input logic [$clog2(ROWS*COLS)-1:0]  b_raddr_o,
  input logic [31:0]                   b_rdata_i,
  input logic                          d_we_o,
  input logic [$clog2(ROWS*COLS)-1:0]  d_waddr_o,
  input logic [31:0]                   d_wdata_o
);
  localparam int AW = $clog2(ROWS*COLS);

  mode_e             mode_c;
  logic [31:0]       rows_c, cols_c;
  logic              rd_q;
  logic [AW-1:0]     rd_addr_c;
  logic [ELEM_W-1:0] op_a, op_b;
  logic              sgn_res, sgn_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_c    <= M_U16;
      rows_c    <= '0;
      cols_c    <= '0;
      rd_q      <= 1'b0;
      rd_addr_c <= '0;
      op_a      <= '0;
      op_b      <= '0;
    end else begin
      if (start_i && !busy_o) begin
        mode_c <= mode_e'(mode_i);
        rows_c <= 32'(rows_i);
        cols_c <= 32'(cols_i);
      end
      rd_q <= a_re_o;
      if (a_re_o) rd_addr_c <= a_raddr_o;
      if (rd_q) begin
        op_a <= widen(mode_c, a_rdata_i);
        op_b <= widen(mode_c, b_rdata_i);
      end
    end
  end

  assign sgn_res = is_narrow(mode_c) ? d_wdata_o[HALF_W-1] : d_wdata_o[ELEM_W-1];
  assign sgn_b   = op_b[ELEM_W-1];

  a_r1_sign_follows_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we_o && is_signed(mode_c) && op_b != '0 && d_wdata_o != '0) |-> (sgn_res == sgn_b));
  a_r2_unsigned_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we_o && !is_signed(mode_c) && op_b != '0) |-> (d_wdata_o < op_b));
  a_r3_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we_o && is_narrow(mode_c)) |-> (d_wdata_o[31:HALF_W] == '0));
  a_r5_same_read_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_re_o |-> (b_re_o && a_raddr_o == b_raddr_o));
  a_r5_write_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_we_o |-> (d_waddr_o == rd_addr_c));
  a_r6_in_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_re_o |-> ((32'(a_raddr_o) / COLS) < rows_c && (32'(a_raddr_o) % COLS) < cols_c));
  a_r6_no_rd_wr_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_re_o && d_we_o));
  a_r7_zero_divisor_writes_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_we_o && op_b == '0) |-> (d_wdata_o == '0 && dz_err_o));
  a_r7_dz_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_err_o |=> dz_err_o);
  a_r9_empty_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (rows_i == '0 || cols_i == '0)) |=> (done_o && !busy_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_busy_fall_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r11_read_then_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_re_o |=> (busy_o && !a_re_o && !d_we_o));
endmodule

bind tile_fmod_engine tfmod_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/sim_tile_fmod_engine.sv
module sim_tile_fmod_engine;
  localparam int R  = 8;
  localparam int C  = 12;
  localparam int N  = R * C;
  localparam int AW = $clog2(N);
  localparam int RW = $clog2(R+1);
  localparam int CW = $clog2(C+1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [RW-1:0] rows_i = '0;
  logic [CW-1:0] cols_i = '0;
  logic          busy_o, done_o, dz_err_o;
  logic          a_re_o, b_re_o, d_we_o;
  logic [AW-1:0] a_raddr_o, b_raddr_o, d_waddr_o;
  logic [31:0]   a_rdata_i = '0, b_rdata_i = '0, d_wdata_o;

  logic [31:0] a_mem [N];
  logic [31:0] b_mem [N];
  logic [31:0] exp_addr_q [$];
  logic [31:0] exp_data_q [$];
  int checks = 0, fails = 0, cyc = 0;
  int cur_rows = 0, cur_cols = 0, rd_cnt = 0;
  string cur_tag = "R1";

  always #5 clk_i = ~clk_i;

  tile_fmod_engine #(.ROWS(R), .COLS(C)) u0 (.*);

  always @(posedge clk_i) begin
    if (a_re_o) a_rdata_i <= a_mem[a_raddr_o];
    if (b_re_o) b_rdata_i <= b_mem[b_raddr_o];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_rem(input int m, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, r;
    case (m)
      0: begin sa = longint'(a[15:0]); sb = longint'(b[15:0]); end
      1: begin sa = longint'($signed(a[15:0])); sb = longint'($signed(b[15:0])); end
      2: begin sa = longint'(a); sb = longint'(b); end
      default: begin sa = longint'($signed(a)); sb = longint'($signed(b)); end
    endcase
    if (sb == 0) return 32'h0;
    r = sa % sb;
    if ((m % 2 == 1) && r != 0 && ((r < 0) != (sb < 0))) r = r + sb;
    return (m < 2) ? {16'h0, r[15:0]} : r[31:0];
  endfunction

  // monitor: reads in order, writes against scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && a_re_o) begin
      logic [31:0] ea;
      if (cur_cols == 0) ea = 32'hffff_ffff;
      else ea = (rd_cnt / cur_cols) * C + rd_cnt % cur_cols;
      chk(b_re_o && a_raddr_o == b_raddr_o, "R5 source addresses", 32'(b_raddr_o), 32'(a_raddr_o));
      chk(32'(a_raddr_o) == ea && rd_cnt < cur_rows * cur_cols, "R5 row-major read", 32'(a_raddr_o), ea);
      rd_cnt++;
    end
    if (rst_ni && d_we_o) begin
      chk(!a_re_o, "R6 read during write", 32'(a_re_o), 32'h0);
      if (exp_addr_q.size() == 0) begin
        chk(1'b0, "R6 extra write", 32'(d_waddr_o), 32'hffff_ffff);
      end else begin
        logic [31:0] ea, ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        chk(32'(d_waddr_o) == ea, "R5 write address", 32'(d_waddr_o), ea);
        chk(d_wdata_o == ed, {cur_tag, " result"}, d_wdata_o, ed);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // kind: 0 nonzero divisors, 1 some zero divisors, 2 corner operands
  task automatic run_tile(input int m, input int rows, input int cols, input int kind,
                          input string tag, input bit disturb);
    for (int i = 0; i < N; i++) begin
      a_mem[i] = $urandom;
      b_mem[i] = $urandom;
      if (i % 2 == 1) begin
        logic [31:0] s;
        s = 32'($urandom % 37);
        b_mem[i] = (i % 4 == 1) ? s : -s;
        b_mem[i][31:16] = (m < 2) ? 16'($urandom) : b_mem[i][31:16];
      end
      if (kind == 1 && i % 5 == 0) b_mem[i] = (m < 2) ? {16'($urandom), 16'h0} : 32'h0;
      else if (kind != 1 && ((m < 2) ? b_mem[i][15:0] == 16'h0 : b_mem[i] == 32'h0))
        b_mem[i] = b_mem[i] | 32'h1;
    end
    if (kind == 2) begin
      a_mem[0] = (m < 2) ? 32'h5a5a_8000 : 32'h8000_0000;
      b_mem[0] = (m < 2) ? 32'h1234_ffff : 32'hffff_ffff;
      a_mem[1] = (m < 2) ? 32'h0000_8000 : 32'h8000_0000;
      b_mem[1] = 32'h0000_0007;
      a_mem[2] = 32'hffff_fff9;
      b_mem[2] = 32'h0000_0007;
    end
    exp_addr_q.delete();
    exp_data_q.delete();
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        exp_addr_q.push_back(32'(r * C + c));
        exp_data_q.push_back(ref_rem(m, a_mem[r*C+c], b_mem[r*C+c]));
      end
    cur_tag  = tag;
    cur_rows = rows;
    cur_cols = cols;
    rd_cnt   = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    mode_i  = 2'(m);
    rows_i  = RW'(rows);
    cols_i  = CW'(cols);
    @(negedge clk_i);
    start_i = 1'b0;
    if (rows == 0 || cols == 0) begin
      chk(done_o && !busy_o, "R9 empty region done", {30'h0, done_o, busy_o}, 32'h2);
      repeat (3) @(negedge clk_i);
      chk(rd_cnt == 0 && !done_o, "R9 no access", 32'(rd_cnt), 32'h0);
      return;
    end
    chk(busy_o && !done_o, "R10 busy after start", {30'h0, busy_o, done_o}, 32'h2);
    if (disturb) begin
      mode_i = mode_i ^ 2'b01;
      rows_i = RW'(R);
      cols_i = CW'(C);
      repeat (40) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    chk(!busy_o, "R10 busy low at done", 32'(busy_o), 32'h0);
    chk(exp_addr_q.size() == 0, {tag, " R6 all elements written"}, 32'(exp_addr_q.size()), 32'h0);
    chk(rd_cnt == rows * cols, "R6 read count", 32'(rd_cnt), 32'(rows * cols));
    @(negedge clk_i);
    chk(!done_o, "R10 done single pulse", 32'(done_o), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !dz_err_o && !a_re_o && !d_we_o, "R10 reset state",
        {27'h0, busy_o, done_o, dz_err_o, a_re_o, d_we_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_tile(3, R, C, 0, "R1", 1'b0);
    run_tile(2, 5, 7, 0, "R2", 1'b0);
    run_tile(1, 3, C, 0, "R3", 1'b0);
    run_tile(0, R, 1, 0, "R3", 1'b0);
    run_tile(3, 2, 3, 2, "R4", 1'b0);
    run_tile(1, 1, 3, 2, "R4", 1'b0);
    run_tile(2, 1, 3, 2, "R2", 1'b0);
    chk(!dz_err_o, "R7 flag clear without zero divisor", 32'(dz_err_o), 32'h0);
    run_tile(3, 4, 4, 0, "R8", 1'b1);
    run_tile(1, 0, 5, 0, "R9", 1'b0);
    run_tile(3, 3, 0, 0, "R9", 1'b0);
    run_tile(3, 3, 5, 1, "R7", 1'b0);
    chk(dz_err_o, "R7 flag set", 32'(dz_err_o), 32'h1);
    run_tile(0, 2, 5, 1, "R7", 1'b0);
    run_tile(2, 2, 2, 0, "R2", 1'b0);
    chk(dz_err_o, "R7 flag sticky", 32'(dz_err_o), 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule